// File: doc/BRIEF.md
# Debug Instruction and Data Transfer Chains

This block holds the two scan chains through which a debugger drives a halted core. The instruction chain receives an opcode from the scan path and hands it to the core as a one-cycle issue pulse. The data chain moves one word at a time between the debugger and the core through two single-entry transfer registers. All work runs in the scan clock domain and is qualified by the TAP state strobes.

The chain-select logic supplies the selected chain number and a decoded instruction, which is either the capture-from-core instruction or the drive-to-core instruction. An opcode is latched on Update-DR. It is issued when Run-Test/Idle is entered, and an issue happens only once for each update. Completion, readiness and overrun status go back to the debugger in the bits captured by the next scan. The debugger rescans until it sees the status it is waiting for.

The core side is kept simple. The core acknowledges each issued instruction with a done strobe. It drains the debugger-to-core register with a take strobe and fills the core-to-debugger register with a put strobe.

Top module: `dbg_xfer_chains`

## Requirements
- R1: After reset `issue_o`, `h2c_full_o` and `c2h_full_o` are 0. A first capture of the instruction chain returns opcode field 0 and completion flag 1.
- R2: The instruction chain is DATA_W+1 bits long and shifts out LSB first. Bits [DATA_W-1:0] capture the latched opcode and bit DATA_W captures the completion flag. Update-DR latches bits [DATA_W-1:0] as the new opcode.
- R3: An Update-DR arms an issue when chain INST_CHAIN (4) or DATA_CHAIN (5) is selected and the capture or drive instruction is active. The first Run-Test/Idle cycle after that update raises `issue_o` for exactly one cycle, in the next clock cycle, with `opcode_o` equal to the latched opcode.
- R4: Remaining in Run-Test/Idle for further cycles, or entering it again without a new Update-DR, produces no further issue.
- R5: An issue is produced only when one of those two chains is selected and either instruction is active at the moment Run-Test/Idle is entered. Entering Run-Test/Idle in any other configuration discards the arm.
- R6: The completion flag clears when an issue is produced and sets again on `done_i`.
- R7: With the drive instruction active on the data chain, a capture loads data 0, Ready (bit DATA_W) as the inverse of the debugger-to-core full flag, and nRetry (bit DATA_W+1) as 1. The following update loads the shifted word and sets full only if that capture reported Ready=1. Otherwise the update is ignored.
- R8: `h2c_take_i` clears `h2c_full_o`.
- R9: With the capture instruction active on the data chain, a capture loads the core-to-debugger word, sets Ready to that register's full flag and empties the register. An update under this instruction leaves the debugger-to-core register unchanged.
- R10: A `c2h_put_i` while the core-to-debugger register is full drops the word and records an overrun. The next capture under the capture instruction reports nRetry=0 and clears the overrun.
- R11: An opcode may be latched and left unissued while a data word is scanned into the debugger-to-core register. The later issue carries the parked opcode, and the data word is already present when the issue occurs.
- R12: `tdo_o` is 0 when neither chain 4 nor chain 5 is selected, or when neither instruction is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| capture_dr_i | input | 1 | TAP in Capture-DR |
| shift_dr_i | input | 1 | TAP in Shift-DR |
| update_dr_i | input | 1 | TAP in Update-DR |
| run_idle_i | input | 1 | TAP in Run-Test/Idle |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, LSB first |
| ir_intest_i | input | 1 | Capture-from-core instruction active |
| ir_extest_i | input | 1 | Drive-to-core instruction active |
| chain_sel_i | input | SEL_W | Selected scan chain number |
| issue_o | output | 1 | One-cycle instruction issue pulse |
| opcode_o | output | DATA_W | Opcode being issued |
| done_i | input | 1 | Core has completed the issued instruction |
| h2c_data_o | output | DATA_W | Debugger-to-core transfer word |
| h2c_full_o | output | 1 | Debugger-to-core word waiting |
| h2c_take_i | input | 1 | Core consumes the debugger-to-core word |
| c2h_data_i | input | DATA_W | Core-to-debugger word |
| c2h_put_i | input | 1 | Core writes the core-to-debugger word |
| c2h_full_o | output | 1 | Core-to-debugger word waiting |

## Verification
Each strobe takes effect on the clock edge at which it is sampled. Full flags, the latched opcode and the completion flag are therefore visible one cycle after the strobe, and `issue_o` is high in the cycle after the first Run-Test/Idle cycle. `tdo_o` is combinational from the head of the selected chain. The bench drives every input on the falling edge. It reads `tdo_o` before the rising edge that shifts the chain, and it reads all registered outputs on the falling edge that follows the edge which updates them. Issue pulses are counted over the whole idle window plus one cycle, so both a missing issue and a repeated issue are detected.

// File: rtl/dbg_xfer_pkg.sv
package dbg_xfer_pkg;
  // decoded TAP activity seen by one chain
  typedef struct packed {
    logic cap;
    logic sft;
    logic upd;
  } chain_strb_t;
endpackage

// File: rtl/dbg_issue_ctrl.sv
module dbg_issue_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              update_dr_i,
  input  logic              run_idle_i,
  input  logic              path_en_i,
  input  logic [DATA_W-1:0] op_i,
  input  logic              done_i,
  output logic              issue_o,
  output logic [DATA_W-1:0] opcode_o,
  output logic              done_flag_o
);
  logic armed_q, issue_q, flag_q;
  logic [DATA_W-1:0] op_q;
  logic fire;

  assign fire = run_idle_i && armed_q && path_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      issue_q <= 1'b0;
      flag_q  <= 1'b1;
      op_q    <= '0;
    end else begin
      // arm on update; any idle cycle consumes or discards the arm
      if (update_dr_i && path_en_i) armed_q <= 1'b1;
      else if (run_idle_i)          armed_q <= 1'b0;
      issue_q <= fire;
      if (fire) op_q <= op_i;
      if (fire)        flag_q <= 1'b0;
      else if (done_i) flag_q <= 1'b1;
    end
  end

  assign issue_o     = issue_q;
  assign opcode_o    = op_q;
  assign done_flag_o = flag_q;
endmodule

// File: rtl/dbg_inst_chain.sv
module dbg_inst_chain
  import dbg_xfer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  chain_strb_t       strb_i,
  input  logic              tdi_i,
  input  logic              flag_i,
  output logic              tdo_o,
  output logic [DATA_W-1:0] op_o
);
  localparam int LEN = DATA_W + 1;

  logic [LEN-1:0]    sr_q;
  logic [DATA_W-1:0] op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
      op_q <= '0;
    end else begin
      if (strb_i.cap)      sr_q <= {flag_i, op_q};
      else if (strb_i.sft) sr_q <= {tdi_i, sr_q[LEN-1:1]};
      if (strb_i.upd) op_q <= sr_q[DATA_W-1:0];
    end
  end

  assign tdo_o = sr_q[0];
  assign op_o  = op_q;
endmodule

// File: rtl/dbg_data_chain.sv
module dbg_data_chain
  import dbg_xfer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  chain_strb_t       strb_i,
  input  logic              intest_i,
  input  logic              extest_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic [DATA_W-1:0] h2c_data_o,
  output logic              h2c_full_o,
  input  logic              h2c_take_i,
  input  logic [DATA_W-1:0] c2h_data_i,
  input  logic              c2h_put_i,
  output logic              c2h_full_o
);
  localparam int LEN = DATA_W + 2;
  localparam int RDY = DATA_W;
  localparam int NRT = DATA_W + 1;

  logic [LEN-1:0]    sr_q;
  logic [DATA_W-1:0] h2c_q, c2h_q;
  logic              h2c_full_q, c2h_full_q, ovr_q, rdy_q;
  logic              cap_in, cap_ex, upd_ex, consume;

  assign cap_in  = strb_i.cap && intest_i;
  assign cap_ex  = strb_i.cap && extest_i && !intest_i;
  assign upd_ex  = strb_i.upd && extest_i && !intest_i;
  assign consume = cap_in && c2h_full_q;

  // scan register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (cap_in) begin
      sr_q <= '0;
      sr_q[DATA_W-1:0] <= c2h_q;
      sr_q[RDY]        <= c2h_full_q;
      sr_q[NRT]        <= !ovr_q;
    end else if (cap_ex) begin
      sr_q <= '0;
      sr_q[RDY] <= !h2c_full_q;
      sr_q[NRT] <= 1'b1;
    end else if (strb_i.sft) begin
      sr_q <= {tdi_i, sr_q[LEN-1:1]};
    end
  end

  // debugger-to-core register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h2c_q      <= '0;
      h2c_full_q <= 1'b0;
      rdy_q      <= 1'b0;
    end else begin
      if (cap_ex)      rdy_q <= !h2c_full_q;
      else if (upd_ex) rdy_q <= 1'b0;
      if (upd_ex && rdy_q) begin
        h2c_q      <= sr_q[DATA_W-1:0];
        h2c_full_q <= 1'b1;
      end else if (h2c_take_i) begin
        h2c_full_q <= 1'b0;
      end
    end
  end

  // core-to-debugger register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c2h_q      <= '0;
      c2h_full_q <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      if (consume) begin
        c2h_full_q <= c2h_put_i;
        if (c2h_put_i) c2h_q <= c2h_data_i;
      end else if (c2h_put_i && !c2h_full_q) begin
        c2h_full_q <= 1'b1;
        c2h_q      <= c2h_data_i;
      end
      if (cap_in)                       ovr_q <= 1'b0;
      else if (c2h_put_i && c2h_full_q) ovr_q <= 1'b1;
    end
  end

  assign tdo_o      = sr_q[0];
  assign h2c_data_o = h2c_q;
  assign h2c_full_o = h2c_full_q;
  assign c2h_full_o = c2h_full_q;
endmodule

// File: rtl/dbg_xfer_chains.sv
module dbg_xfer_chains
  import dbg_xfer_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SEL_W      = 5,
  parameter int INST_CHAIN = 4,
  parameter int DATA_CHAIN = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_dr_i,
  input  logic              shift_dr_i,
  input  logic              update_dr_i,
  input  logic              run_idle_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  input  logic              ir_intest_i,
  input  logic              ir_extest_i,
  input  logic [SEL_W-1:0]  chain_sel_i,
  output logic              issue_o,
  output logic [DATA_W-1:0] opcode_o,
  input  logic              done_i,
  output logic [DATA_W-1:0] h2c_data_o,
  output logic              h2c_full_o,
  input  logic              h2c_take_i,
  input  logic [DATA_W-1:0] c2h_data_i,
  input  logic              c2h_put_i,
  output logic              c2h_full_o
);
  localparam logic [SEL_W-1:0] INST_ID = SEL_W'(INST_CHAIN);
  localparam logic [SEL_W-1:0] DATA_ID = SEL_W'(DATA_CHAIN);

  logic        ir_ok, inst_sel, data_sel, path_en;
  logic        inst_tdo, data_tdo, flag;
  logic [DATA_W-1:0] op_latched;
  chain_strb_t inst_strb, data_strb;

  assign ir_ok    = ir_intest_i || ir_extest_i;
  assign inst_sel = ir_ok && (chain_sel_i == INST_ID);
  assign data_sel = ir_ok && (chain_sel_i == DATA_ID);
  assign path_en  = inst_sel || data_sel;

  assign inst_strb = '{cap: capture_dr_i && inst_sel, sft: shift_dr_i && inst_sel,
                       upd: update_dr_i && inst_sel};
  assign data_strb = '{cap: capture_dr_i && data_sel, sft: shift_dr_i && data_sel,
                       upd: update_dr_i && data_sel};

  dbg_inst_chain #(.DATA_W(DATA_W)) u_inst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .strb_i (inst_strb),
    .tdi_i  (tdi_i),
    .flag_i (flag),
    .tdo_o  (inst_tdo),
    .op_o   (op_latched)
  );

  dbg_data_chain #(.DATA_W(DATA_W)) u_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strb_i     (data_strb),
    .intest_i   (ir_intest_i),
    .extest_i   (ir_extest_i),
    .tdi_i      (tdi_i),
    .tdo_o      (data_tdo),
    .h2c_data_o (h2c_data_o),
    .h2c_full_o (h2c_full_o),
    .h2c_take_i (h2c_take_i),
    .c2h_data_i (c2h_data_i),
    .c2h_put_i  (c2h_put_i),
    .c2h_full_o (c2h_full_o)
  );

  dbg_issue_ctrl #(.DATA_W(DATA_W)) u_issue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .update_dr_i (update_dr_i),
    .run_idle_i  (run_idle_i),
    .path_en_i   (path_en),
    .op_i        (op_latched),
    .done_i      (done_i),
    .issue_o     (issue_o),
    .opcode_o    (opcode_o),
    .done_flag_o (flag)
  );

  always_comb begin
    if (inst_sel)      tdo_o = inst_tdo;
    else if (data_sel) tdo_o = data_tdo;
    else               tdo_o = 1'b0;
  end
endmodule

// File: rtl/dbg_xfer_chains_chk.sv
module dbg_xfer_chains_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic update_dr_i,
  input logic run_idle_i,
  input logic capture_dr_i,
  input logic ir_intest_i,
  input logic ir_extest_i,
  input logic issue_o,
  input logic h2c_full_o,
  input logic h2c_take_i,
  input logic c2h_full_o
);
  // R3
  issue_after_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> $past(run_idle_i));

  // R4
  no_reissue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_idle_i && $past(run_idle_i) && !$past(update_dr_i)) |=> !issue_o);

  // R7
  h2c_fill_on_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(h2c_full_o) |-> $past(update_dr_i && ir_extest_i));

  // R8
  h2c_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h2c_full_o && h2c_take_i) |=> !h2c_full_o);

  // R10
  c2h_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c2h_full_o && !(capture_dr_i && ir_intest_i)) |=> c2h_full_o);
endmodule

bind dbg_xfer_chains dbg_xfer_chains_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .update_dr_i  (update_dr_i),
  .run_idle_i   (run_idle_i),
  .capture_dr_i (capture_dr_i),
  .ir_intest_i  (ir_intest_i),
  .ir_extest_i  (ir_extest_i),
  .issue_o      (issue_o),
  .h2c_full_o   (h2c_full_o),
  .h2c_take_i   (h2c_take_i),
  .c2h_full_o   (c2h_full_o)
);

// File: tb/dbg_xfer_chains_bench.sv
`timescale 1ns/1ps
module dbg_xfer_chains_bench;
  logic        clk = 0, rst_ni = 0;
  logic        cap = 0, sft = 0, upd = 0, idle = 0, tdi = 0;
  logic        tdo, intest = 0, extest = 0;
  logic [4:0]  sel = 0;
  logic        issue, done = 0, h2c_full, take = 0, put = 0, c2h_full;
  logic [31:0] opcode, h2c_data, c2h_data = 0;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  dbg_xfer_chains u_dbg_xfer_chains (
    .clk_i(clk), .rst_ni(rst_ni), .capture_dr_i(cap), .shift_dr_i(sft),
    .update_dr_i(upd), .run_idle_i(idle), .tdi_i(tdi), .tdo_o(tdo),
    .ir_intest_i(intest), .ir_extest_i(extest), .chain_sel_i(sel),
    .issue_o(issue), .opcode_o(opcode), .done_i(done),
    .h2c_data_o(h2c_data), .h2c_full_o(h2c_full), .h2c_take_i(take),
    .c2h_data_i(c2h_data), .c2h_put_i(put), .c2h_full_o(c2h_full)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // capture, shift len bits LSB first, optional update; starts and ends at negedge
  task automatic scan(input int len, input logic [33:0] din, input bit do_upd,
                      output logic [33:0] dout);
    dout = '0;
    cap = 1; @(negedge clk); cap = 0; sft = 1;
    for (int i = 0; i < len; i++) begin
      tdi = din[i];
      #1 dout[i] = tdo;
      @(negedge clk);
    end
    sft = 0;
    if (do_upd) begin upd = 1; @(negedge clk); upd = 0; end
  endtask

  task automatic run_idle(input int n, output int cnt, output logic [31:0] op);
    cnt = 0; op = '0;
    idle = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == n - 1) idle = 0;
      #1 if (issue) begin cnt++; op = opcode; end
    end
    @(negedge clk);
    #1 if (issue) begin cnt++; op = opcode; end
  endtask

  task automatic set_path(input logic [4:0] s, input bit in_m, input bit ex_m);
    sel = s; intest = in_m; extest = ex_m;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [33:0] d;
    logic [31:0] op, w1, w2;
    int cnt;
    cyc(3); rst_ni = 1; cyc(1);

    // R1 reset state
    chk(issue == 0 && h2c_full == 0 && c2h_full == 0, "R1", "reset outputs",
        {issue, h2c_full, c2h_full}, 0);
    set_path(5'd4, 0, 1);
    scan(33, '0, 0, d);
    chk(d[32:0] == {1'b1, 32'h0}, "R1", "first inst capture", d[32:0], {1'b1, 32'h0});

    // R2 R3 R4 R6 opcode sweep with varying core latency
    for (int k = 0; k < 8; k++) begin
      logic [31:0] v;
      v = (32'h1 << (k * 4)) ^ (32'h9E37_79B9 * (k + 1));
      set_path(5'd4, k[0], !k[0]);
      scan(33, {2'b0, v}, 1, d);
      run_idle(3, cnt, op);
      chk(cnt == 1, "R3", "issue count", cnt, 1);
      chk(op == v, "R3", "issued opcode", op, v);
      scan(33, '0, 0, d);
      chk(d[32:0] == {1'b0, v}, "R2", "capture before done", d[32:0], {1'b0, v});
      cyc(k);
      done = 1; cyc(1); done = 0;
      scan(33, '0, 0, d);
      chk(d[32] == 1'b1, "R6", "flag after done", d[32], 1);
      run_idle(2, cnt, op);
      chk(cnt == 0, "R4", "no reissue without update", cnt, 0);
    end

    // R5 R12 sweep over chain and instruction
    for (int s = 0; s < 8; s++) begin
      for (int m = 0; m < 4; m++) begin
        int exp_n;
        exp_n = ((s == 4 || s == 5) && m != 0) ? 1 : 0;
        set_path(5'd4, 0, 1);
        scan(33, {2'b0, 32'hA5A5_0000 | 32'(s * 4 + m)}, 1, d);
        set_path(5'(s), m[0], m[1]);
        #1 if (exp_n == 0)
          chk(tdo == 0, "R12", "tdo idle path", tdo, 0);
        run_idle(2, cnt, op);
        chk(cnt == exp_n, "R5", "issue by path", cnt, exp_n);
        set_path(5'd4, 0, 1);
        run_idle(1, cnt, op);
        chk(cnt == 0, "R5", "arm discarded", cnt, 0);
      end
    end

    // R7 R8 debugger-to-core
    w1 = 32'hCAFE_0123; w2 = 32'h0BAD_F00D;
    set_path(5'd5, 0, 1);
    scan(34, {2'b0, w1}, 1, d);
    chk(d[33:32] == 2'b11 && d[31:0] == 0, "R7", "ready capture", d, {2'b11, 32'h0});
    chk(h2c_full && h2c_data == w1, "R7", "word loaded", h2c_data, w1);
    scan(34, {2'b0, w2}, 1, d);
    chk(d[32] == 0, "R7", "not ready while full", d[32], 0);
    chk(h2c_data == w1, "R7", "update ignored", h2c_data, w1);
    take = 1; cyc(1); take = 0;
    chk(h2c_full == 0, "R8", "take clears full", h2c_full, 0);
    scan(34, {2'b0, w2}, 1, d);
    chk(d[32] == 1 && h2c_data == w2, "R7", "retry accepted", h2c_data, w2);
    take = 1; cyc(1); take = 0;

    // R11 parked opcode then data word
    set_path(5'd4, 0, 1);
    scan(33, {2'b0, 32'h1357_9BDF}, 1, d);
    set_path(5'd5, 0, 1);
    scan(34, {2'b0, w1}, 1, d);
    idle = 1; @(negedge clk); idle = 0;
    #1 chk(issue && opcode == 32'h1357_9BDF, "R11", "parked opcode issued", opcode, 32'h1357_9BDF);
    chk(h2c_full && h2c_data == w1, "R11", "data present at issue", h2c_data, w1);
    cyc(1);
    take = 1; cyc(1); take = 0;

    // R9 R10 core-to-debugger
    set_path(5'd5, 1, 0);
    scan(34, {2'b0, 32'hFFFF_FFFF}, 1, d);
    chk(d[33:32] == 2'b10, "R9", "empty capture", d[33:32], 2'b10);
    chk(h2c_full == 0, "R9", "update under capture instr", h2c_full, 0);
    c2h_data = 32'h1111_2222; put = 1; cyc(1); put = 0;
    chk(c2h_full == 1, "R9", "put fills", c2h_full, 1);
    scan(34, '0, 0, d);
    chk(d == {2'b11, 32'h1111_2222}, "R9", "read word", d, {2'b11, 32'h1111_2222});
    chk(c2h_full == 0, "R9", "capture empties", c2h_full, 0);
    c2h_data = 32'h3333_4444; put = 1; cyc(1);
    c2h_data = 32'h5555_6666; cyc(1); put = 0;
    scan(34, '0, 0, d);
    chk(d == {2'b01, 32'h3333_4444}, "R10", "overrun report", d, {2'b01, 32'h3333_4444});
    scan(34, '0, 0, d);
    chk(d[33:32] == 2'b10, "R10", "overrun cleared", d[33:32], 2'b10);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule